// File: doc/BRIEF.md
# SPI Frame Packing Data Path

This block is the data path between an SPI shift engine and a register-access bus. It holds a transmit queue and a receive queue of small frames, 4 to 8 bits wide. When packing is on, one 16-bit bus access moves two frames. A narrow access moves one frame. The receive-ready flag waits for a full pair while packing is on and for a single frame while it is off. This lets software finish an odd-length transfer with one narrow access.

The block also resolves the slave-select level. The level comes from the external pin, or from a software bit when software-select mode is on. The shift engine may only move frames while that level is low. Frame bits at or above the configured width are cleared on the way into both queues.

Top module: `spi_pack_dp`

## Requirements
- R1: After reset, `rx_ready_o`, `tx_valid_o`, `tx_ovf_o` and `rx_half_o` are all 0.
- R2: Packing is on when `byte_acc_i` is 0 and `width_i` is 8 or less. With packing on, a 16-bit write (`wr_wide_i`=1) queues two frames. Bits [7:0] go to the engine first and bits [15:8] go second.
- R3: A narrow write, or any write with packing off (`byte_acc_i`=1), queues one frame taken from bits [7:0].
- R4: A write that needs more slots than the transmit queue had free at the start of the cycle is dropped as a whole. It sets the sticky `tx_ovf_o`, which stays set until `ovf_clr_i` is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R5: With packing on, `rx_ready_o` is 1 only when at least two frames are held. With packing off, it is 1 when at least one frame is held. The threshold follows the current `byte_acc_i`.
- R6: With packing on and at least two frames held, a 16-bit read returns the older frame in bits [7:0] and the newer frame in bits [15:8], and removes both.
- R7: A 16-bit read that finds one frame, or any read with packing off, returns that frame in bits [7:0] with zeros above and removes one frame. A read of an empty queue returns 0.
- R8: `rx_half_o` is 1 while the receive queue holds at least half its depth (2 of 4 frames).
- R9: With `sw_sel_en_i`=0 the select level equals `sel_pin_i`. With `sw_sel_en_i`=1 it equals `sw_sel_i`, and the pin is ignored. `sel_active_o` is 1 when the level is low.
- R10: `rx_push_i` and `tx_pop_i` take effect only while `sel_active_o` is 1. A receive push into a full queue (4 frames) is dropped.
- R11: Frame bits at positions `width_i` and above are stored as 0 in both queues.
- R12: A receive push and a bus read in the same cycle both take effect. The read sees only the frames held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| width_i | input | 4 | Frame width in bits (4 to 8) |
| byte_acc_i | input | 1 | 0 enables packing, 1 forces one frame per access |
| wr_en_i | input | 1 | Bus write strobe |
| wr_wide_i | input | 1 | Write is 16 bits wide |
| wr_data_i | input | 16 | Bus write data |
| rd_en_i | input | 1 | Bus read strobe |
| rd_wide_i | input | 1 | Read is 16 bits wide |
| rd_data_o | output | 16 | Bus read data, valid while `rd_en_i` is 1 |
| rx_ready_o | output | 1 | Receive-ready flag |
| rx_half_o | output | 1 | Receive queue at or above half depth |
| tx_ovf_o | output | 1 | Sticky transmit overflow |
| ovf_clr_i | input | 1 | Clears `tx_ovf_o` |
| tx_valid_o | output | 1 | Transmit queue holds a frame |
| tx_frame_o | output | 8 | Frame at the head of the transmit queue |
| tx_pop_i | input | 1 | Engine takes the head frame |
| rx_push_i | input | 1 | Engine delivers a received frame |
| rx_frame_i | input | 8 | Received frame |
| sw_sel_en_i | input | 1 | Selects the software bit as select source |
| sw_sel_i | input | 1 | Software select level |
| sel_pin_i | input | 1 | External select pin level |
| sel_active_o | output | 1 | Resolved select level is low |

## Verification
Two events can land on the receive queue in the same cycle: the engine can deliver a frame while the bus does a packed 16-bit read. The bench loads two frames, then asserts `rx_push_i` and a 16-bit read in one cycle. It expects the returned word to hold only the two older frames. It then expects exactly the new frame to remain, which is shown by `rx_ready_o` with packing off and by a following narrow read.

// File: rtl/spi_pack_pkg.sv
package spi_pack_pkg;
  localparam int PACK_MAX_W = 8;

  // number of frames moved into or out of a queue in one cycle
  typedef enum logic [1:0] {
    MV_NONE = 2'd0,
    MV_ONE  = 2'd1,
    MV_TWO  = 2'd2
  } move_e;
endpackage

// File: rtl/spi_pair_fifo.sv
module spi_pair_fifo
  import spi_pack_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  move_e         push_n_i,
  input  logic [W-1:0]  push_d0_i,
  input  logic [W-1:0]  push_d1_i,
  input  move_e         pop_n_i,
  output logic [W-1:0]  head0_o,
  output logic [W-1:0]  head1_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_n_i != MV_NONE) mem_q[wr_ptr_q] <= push_d0_i;
    if (push_n_i == MV_TWO)  mem_q[wr_ptr_q + PW'(1)] <= push_d1_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + PW'(push_n_i);
      rd_ptr_q <= rd_ptr_q + PW'(pop_n_i);
      cnt_q    <= cnt_q + CW'(push_n_i) - CW'(pop_n_i);
    end
  end

  assign head0_o = mem_q[rd_ptr_q];
  assign head1_o = mem_q[rd_ptr_q + PW'(1)];
  assign count_o = cnt_q;

  // R10: callers never pop more than held nor push past depth
  assert_no_underflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CW'(pop_n_i) <= cnt_q);
  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q - CW'(pop_n_i) + CW'(push_n_i)) <= CW'(DEPTH));
  assert_ptr_track_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q < CW'(DEPTH)) |-> (PW'(wr_ptr_q - rd_ptr_q) == cnt_q[PW-1:0]));
endmodule

// File: rtl/spi_sel_resolve.sv
module spi_sel_resolve (
  input  logic sw_sel_en_i,
  input  logic sw_sel_i,
  input  logic sel_pin_i,
  output logic sel_level_o,
  output logic sel_active_o
);
  always_comb begin
    sel_level_o  = sw_sel_en_i ? sw_sel_i : sel_pin_i;
    sel_active_o = ~sel_level_o;
  end
endmodule

// File: rtl/spi_pack_dp.sv
module spi_pack_dp
  import spi_pack_pkg::*;
#(
  parameter int FRAME_W  = 8,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [$clog2(FRAME_W+1)-1:0] width_i,
  input  logic                         byte_acc_i,
  input  logic                         wr_en_i,
  input  logic                         wr_wide_i,
  input  logic [2*FRAME_W-1:0]         wr_data_i,
  input  logic                         rd_en_i,
  input  logic                         rd_wide_i,
  output logic [2*FRAME_W-1:0]         rd_data_o,
  output logic                         rx_ready_o,
  output logic                         rx_half_o,
  output logic                         tx_ovf_o,
  input  logic                         ovf_clr_i,
  output logic                         tx_valid_o,
  output logic [FRAME_W-1:0]           tx_frame_o,
  input  logic                         tx_pop_i,
  input  logic                         rx_push_i,
  input  logic [FRAME_W-1:0]           rx_frame_i,
  input  logic                         sw_sel_en_i,
  input  logic                         sw_sel_i,
  input  logic                         sel_pin_i,
  output logic                         sel_active_o
);
  localparam int WW   = $clog2(FRAME_W + 1);
  localparam int TCW  = $clog2(TX_DEPTH + 1);
  localparam int RCW  = $clog2(RX_DEPTH + 1);
  localparam logic [TCW-1:0] TX_FULL = TCW'(TX_DEPTH);
  localparam logic [RCW-1:0] RX_FULL = RCW'(RX_DEPTH);
  localparam logic [RCW-1:0] RX_HALF = RCW'(RX_DEPTH / 2);

  logic               sel_level;
  logic               pack_on;
  logic [FRAME_W-1:0] fmask;

  spi_sel_resolve u_sel (
    .sw_sel_en_i (sw_sel_en_i),
    .sw_sel_i    (sw_sel_i),
    .sel_pin_i   (sel_pin_i),
    .sel_level_o (sel_level),
    .sel_active_o(sel_active_o)
  );

  always_comb begin
    for (int i = 0; i < FRAME_W; i++) fmask[i] = (WW'(i) < width_i);
  end

  assign pack_on = ~byte_acc_i && (width_i <= WW'(PACK_MAX_W));

  // ---------------- transmit side ----------------
  move_e              tx_push_n, tx_pop_n;
  logic [TCW-1:0]     tx_cnt, tx_free, tx_need;
  logic [FRAME_W-1:0] tx_head0, tx_head1;
  logic               tx_accept, tx_pop_ok, ovf_q;

  always_comb begin
    tx_need   = (wr_wide_i && pack_on) ? TCW'(2) : TCW'(1);
    tx_free   = TX_FULL - tx_cnt;
    tx_accept = wr_en_i && (tx_free >= tx_need);
    tx_push_n = !tx_accept ? MV_NONE : (tx_need == TCW'(2)) ? MV_TWO : MV_ONE;
    tx_pop_ok = tx_pop_i && sel_active_o && (tx_cnt != '0);
    tx_pop_n  = tx_pop_ok ? MV_ONE : MV_NONE;
  end

  spi_pair_fifo #(.W(FRAME_W), .DEPTH(TX_DEPTH)) u_tx_q (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_n_i (tx_push_n),
    .push_d0_i(wr_data_i[FRAME_W-1:0] & fmask),
    .push_d1_i(wr_data_i[2*FRAME_W-1:FRAME_W] & fmask),
    .pop_n_i  (tx_pop_n),
    .head0_o  (tx_head0),
    .head1_o  (tx_head1),
    .count_o  (tx_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ovf_q <= 1'b0;
    else if (wr_en_i && !tx_accept) ovf_q <= 1'b1;
    else if (ovf_clr_i)            ovf_q <= 1'b0;
  end

  assign tx_ovf_o   = ovf_q;
  assign tx_valid_o = (tx_cnt != '0);
  assign tx_frame_o = tx_head0;

  // ---------------- receive side ----------------
  move_e              rx_push_n, rx_pop_n;
  logic [RCW-1:0]     rx_cnt;
  logic [FRAME_W-1:0] rx_head0, rx_head1;
  logic               rx_ok, rd_pair;

  always_comb begin
    rx_ok     = rx_push_i && sel_active_o && (rx_cnt < RX_FULL);
    rx_push_n = rx_ok ? MV_ONE : MV_NONE;
    rd_pair   = rd_en_i && rd_wide_i && pack_on && (rx_cnt >= RCW'(2));
    if (!rd_en_i || rx_cnt == '0) rx_pop_n = MV_NONE;
    else if (rd_pair)             rx_pop_n = MV_TWO;
    else                          rx_pop_n = MV_ONE;
    rd_data_o = '0;
    if (rx_pop_n != MV_NONE) rd_data_o[FRAME_W-1:0] = rx_head0;
    if (rd_pair)             rd_data_o[2*FRAME_W-1:FRAME_W] = rx_head1;
  end

  spi_pair_fifo #(.W(FRAME_W), .DEPTH(RX_DEPTH)) u_rx_q (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_n_i (rx_push_n),
    .push_d0_i(rx_frame_i & fmask),
    .push_d1_i('0),
    .pop_n_i  (rx_pop_n),
    .head0_o  (rx_head0),
    .head1_o  (rx_head1),
    .count_o  (rx_cnt)
  );

  assign rx_ready_o = pack_on ? (rx_cnt >= RCW'(2)) : (rx_cnt != '0);
  assign rx_half_o  = (rx_cnt >= RX_HALF);

  // ---------------- assertions ----------------
  assert_ovf_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ovf_o && !ovf_clr_i) |=> tx_ovf_o);
  assert_full_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt == TX_FULL && wr_en_i) |=> tx_ovf_o);
  assert_pair_pop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_wide_i && !byte_acc_i && rx_cnt >= RCW'(2) && !rx_push_i)
      |=> (rx_cnt == $past(rx_cnt) - RCW'(2)));
  assert_rx_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_active_o && !rd_en_i) |=> $stable(rx_cnt));
  assert_tx_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_active_o && !wr_en_i) |=> $stable(tx_cnt));
  assert_sel_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_sel_en_i |-> (sel_level == sw_sel_i));
endmodule

// File: tb/sim_spi_pack_dp.sv
module sim_spi_pack_dp;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  width = 4'd8;
  logic        byte_acc = 1'b0;
  logic        wr_en = 1'b0, wr_wide = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0, rd_wide = 1'b0;
  logic [15:0] rd_data;
  logic        rx_ready, rx_half, tx_ovf, tx_valid, sel_active;
  logic        ovf_clr = 1'b0;
  logic [7:0]  tx_frame;
  logic        tx_pop = 1'b0, rx_push = 1'b0;
  logic [7:0]  rx_frame = '0;
  logic        sw_en = 1'b1, sw_bit = 1'b0, pin = 1'b1;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_pack_dp u0 (
    .clk_i(clk), .rst_ni(rst_n), .width_i(width), .byte_acc_i(byte_acc),
    .wr_en_i(wr_en), .wr_wide_i(wr_wide), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_wide_i(rd_wide), .rd_data_o(rd_data),
    .rx_ready_o(rx_ready), .rx_half_o(rx_half), .tx_ovf_o(tx_ovf),
    .ovf_clr_i(ovf_clr), .tx_valid_o(tx_valid), .tx_frame_o(tx_frame),
    .tx_pop_i(tx_pop), .rx_push_i(rx_push), .rx_frame_i(rx_frame),
    .sw_sel_en_i(sw_en), .sw_sel_i(sw_bit), .sel_pin_i(pin),
    .sel_active_o(sel_active)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input bit wide, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_wide = wide; wr_data = d;
    @(posedge clk); #1 wr_en = 0; wr_wide = 0;
  endtask

  task automatic bus_rd(input bit wide, input logic [15:0] exp, input string tag);
    @(negedge clk); rd_en = 1; rd_wide = wide;
    #1 chk(rd_data == exp, tag, rd_data, exp);
    @(posedge clk); #1 rd_en = 0; rd_wide = 0;
  endtask

  task automatic eng_pop(input logic [7:0] exp, input string tag);
    @(negedge clk);
    chk(tx_valid && tx_frame == exp, tag, {tx_valid, tx_frame}, {1'b1, exp});
    tx_pop = 1;
    @(posedge clk); #1 tx_pop = 0;
  endtask

  task automatic eng_push(input logic [7:0] f);
    @(negedge clk); rx_push = 1; rx_frame = f;
    @(posedge clk); #1 rx_push = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk({rx_ready, tx_valid, tx_ovf, rx_half} == 4'b0, "R1 reset flags",
        {rx_ready, tx_valid, tx_ovf, rx_half}, 0);
  endtask

  task automatic t_tx_pack;
    byte_acc = 0;
    bus_wr(1, 16'hB2A1);
    eng_pop(8'hA1, "R2 low byte first");
    eng_pop(8'hB2, "R2 high byte second");
    @(negedge clk) chk(!tx_valid, "R2 drained", tx_valid, 0);
  endtask

  task automatic t_tx_narrow;
    bus_wr(0, 16'hEE5C);
    eng_pop(8'h5C, "R3 narrow one frame");
    @(negedge clk) chk(!tx_valid, "R3 narrow single", tx_valid, 0);
    byte_acc = 1;
    bus_wr(1, 16'h3377);
    eng_pop(8'h77, "R3 packing off wide");
    @(negedge clk) chk(!tx_valid, "R3 packing off single", tx_valid, 0);
    byte_acc = 0;
  endtask

  task automatic t_tx_ovf;
    bus_wr(0, 16'h0001); bus_wr(0, 16'h0002); bus_wr(0, 16'h0003);
    bus_wr(1, 16'h0504);
    @(negedge clk) chk(tx_ovf, "R4 pair into one slot", tx_ovf, 1);
    bus_wr(0, 16'h0006);
    bus_wr(0, 16'h0007);
    eng_pop(8'h01, "R4 order 1"); eng_pop(8'h02, "R4 order 2");
    eng_pop(8'h03, "R4 order 3"); eng_pop(8'h06, "R4 fits after drop");
    @(negedge clk) chk(!tx_valid && tx_ovf, "R4 drop and sticky", {tx_valid, tx_ovf}, 2'b01);
    @(negedge clk); ovf_clr = 1; @(posedge clk); #1 ovf_clr = 0;
    @(negedge clk) chk(!tx_ovf, "R4 clear", tx_ovf, 0);
  endtask

  task automatic t_rx_pack;
    eng_push(8'h11);
    @(negedge clk) chk(!rx_ready && !rx_half, "R5 one frame packed", {rx_ready, rx_half}, 0);
    byte_acc = 1;
    #1 chk(rx_ready, "R5 one frame unpacked", rx_ready, 1);
    byte_acc = 0;
    eng_push(8'h22);
    @(negedge clk) chk(rx_ready && rx_half, "R5 R8 pair ready", {rx_ready, rx_half}, 2'b11);
    bus_rd(1, 16'h2211, "R6 packed read");
    @(negedge clk) chk(!rx_ready && !rx_half, "R6 both removed", {rx_ready, rx_half}, 0);
  endtask

  task automatic t_rx_odd;
    eng_push(8'h33);
    bus_rd(1, 16'h0033, "R7 lone frame wide read");
    bus_rd(0, 16'h0000, "R7 empty read");
  endtask

  task automatic t_width;
    width = 4'd5;
    eng_push(8'hFF);
    bus_rd(0, 16'h001F, "R11 rx masked");
    bus_wr(1, 16'hFFFF);
    eng_pop(8'h1F, "R11 tx masked low");
    eng_pop(8'h1F, "R11 tx masked high");
    width = 4'd8;
  endtask

  task automatic t_sel;
    sw_en = 0; pin = 1;
    #1 chk(!sel_active, "R9 pin high", sel_active, 0);
    pin = 0;
    #1 chk(sel_active, "R9 pin low", sel_active, 1);
    sw_en = 1; sw_bit = 1;
    #1 chk(!sel_active, "R9 pin ignored", sel_active, 0);
    byte_acc = 1;
    eng_push(8'h44);
    @(negedge clk) chk(!rx_ready, "R10 push gated", rx_ready, 0);
    bus_wr(0, 16'h0055);
    @(negedge clk); tx_pop = 1; @(posedge clk); #1 tx_pop = 0;
    sw_bit = 0;
    eng_pop(8'h55, "R10 pop gated");
    byte_acc = 0;
  endtask

  task automatic t_rx_full;
    for (int i = 1; i <= 5; i++) eng_push(8'(i));
    for (int i = 1; i <= 4; i++) bus_rd(0, 16'(i), "R10 full order");
    @(negedge clk) chk(!rx_ready && !rx_half, "R10 fifth dropped", {rx_ready, rx_half}, 0);
  endtask

  task automatic t_same_cycle;
    eng_push(8'hA0); eng_push(8'hB0);
    @(negedge clk); rx_push = 1; rx_frame = 8'hC0; rd_en = 1; rd_wide = 1;
    #1 chk(rd_data == 16'hB0A0, "R12 read sees old pair", rd_data, 16'hB0A0);
    @(posedge clk); #1 rx_push = 0; rd_en = 0; rd_wide = 0;
    byte_acc = 1;
    @(negedge clk) chk(rx_ready && !rx_half, "R12 one left", {rx_ready, rx_half}, 2'b10);
    bus_rd(0, 16'h00C0, "R12 new frame kept");
    byte_acc = 0;
  endtask

  initial begin
    #(CLK_P * 3) rst_n = 1;
    t_reset(); t_tx_pack(); t_tx_narrow(); t_tx_ovf();
    t_rx_pack(); t_rx_odd(); t_width(); t_sel(); t_rx_full(); t_same_cycle();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: act=%h exp=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule